// File: doc/BRIEF.md
# Converter Control and Timing Registers

This block is the digital side of a two-channel, 10-bit analog-to-digital converter attached to an 8-bit processor's special-function-register bus. Software sees two byte registers at fixed addresses. The control register holds the enable, the start/busy bit, the end-of-conversion flag, a CPU-suspend request and the channel choice. The divider register sets the converter clock rate.

A conversion starts when software writes the start bit with the enable bit set. The block then runs a divided converter clock for a fixed number of periods. On the last edge it latches the 10-bit sample presented by the analog macro and raises the end-of-conversion flag. An interrupt follows when the external interrupt-enable input is high. While the conversion runs, the start bit reads as 1, so it serves as a busy indicator. The suspend request, if asked for, is held for the whole conversion.

Top module: `adc_ctl`

## Requirements
- R1: After reset, both registers read 00h, `conv_clk`, `cpu_suspend` and `adc_irq` are low, `adc_chan` is 1 and `conv_result` is 0.
- R2: The control register is at address F3h and the divider register at F2h. Any other address reads 00h. Control bits 7, 2 and 1 and divider bits 7 to 5 always read 0, whatever was written to them.
- R3: A control write with bit 5 (enable) = 1 and bit 3 (start) = 1 while idle begins a conversion. Bit 3 reads 1 for exactly 22*(N+1) system clocks and then clears itself, where N is the divider value in bits 4 to 0 of F2h.
- R4: During a conversion, `conv_clk` starts low and toggles every N+1 system clocks. Its first rise is N+1 clocks after the start write, and it rises 11 times per conversion. It stays low while no conversion runs.
- R5: `conv_result` takes the value `sample_in` has in the last system clock of the conversion, and it holds that value until the next conversion completes.
- R6: The end-of-conversion flag (control bit 4) is set when a conversion completes. It stays set until a control write carries 0 in bit 4. Writing 1 to this bit never sets it.
- R7: `adc_irq` is high exactly when the end-of-conversion flag is set and `irq_en` is high.
- R8: Control bit 6, written together with a start, drives `cpu_suspend` high for the whole conversion and clears itself at the end. Written without a start, it reads back 0.
- R9: With the enable bit clear, a start write is ignored: bit 3 stays 0, no flag is raised, and `conv_clk` stays low.
- R10: While a conversion runs, control writes to bits 6, 3 and 0 are ignored, and the conversion length is unchanged.
- R11: Clearing the enable bit during a conversion aborts it. Busy, suspend and `conv_clk` drop, the flag is not set, and `conv_result` keeps its value.
- R12: `adc_chan` gives the selected channel. Control bit 0 = 1 selects channel 0, and bit 0 = 0 selects channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Write strobe, one cycle per write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr`, combinational |
| irq_en | input | 1 | Interrupt enable for this converter |
| sample_in | input | 10 | Conversion value from the analog macro |
| conv_result | output | 10 | Latched conversion result |
| conv_clk | output | 1 | Divided converter clock |
| adc_chan | output | 1 | Selected channel index |
| cpu_suspend | output | 1 | Request to suspend the CPU core |
| adc_irq | output | 1 | Conversion-done interrupt |

## Verification
The divider is swept over all 32 values, with a conversion at each setting. The measured busy length and the position of the first converter-clock rise separate an off-by-one in the divide from an off-by-one in the period count. `sample_in` changes on every clock during each conversion, so a capture one cycle early or late, or at the start, shows up as a wrong result. The suspend bit and `irq_en` alternate with the divider's parity, to show that each acts only where it should. Separate runs cover a start with the enable bit clear, a start rewrite in mid-conversion, and an abort caused by clearing the enable bit.

// File: rtl/adc_ctl.sv
module adc_ctl #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'hF3,
  parameter logic [7:0]  DIV_ADDR  = 8'hF2,
  parameter int          DIV_W     = 5,
  parameter int          RES_W     = 10,
  parameter int          CONV_CLKS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              irq_en,
  input  logic [RES_W-1:0]  sample_in,
  output logic [RES_W-1:0]  conv_result,
  output logic              conv_clk,
  output logic              adc_chan,
  output logic              cpu_suspend,
  output logic              adc_irq
);
  localparam int CW = $clog2(CONV_CLKS + 1);

  logic             pidle, en, eoc, busy, chsel;
  logic [DIV_W-1:0] div, dcnt;
  logic [CW-1:0]    ccnt;
  logic             wr_ctrl, wr_div, start, abort, tick, done;
  logic             wdata_unused;

  assign wr_ctrl = sfr_wr && (sfr_addr == ADDR_W'(CTRL_ADDR));
  assign wr_div  = sfr_wr && (sfr_addr == ADDR_W'(DIV_ADDR));
  assign start   = wr_ctrl && !busy && sfr_wdata[5] && sfr_wdata[3];
  assign abort   = wr_ctrl && busy && !sfr_wdata[5];
  assign tick    = busy && (dcnt >= div);
  assign done    = tick && conv_clk && (ccnt == CW'(CONV_CLKS)) && !abort;
  assign wdata_unused = ^{sfr_wdata[7], sfr_wdata[2:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pidle <= 1'b0;
      en    <= 1'b0;
      eoc   <= 1'b0;
      busy  <= 1'b0;
      chsel <= 1'b0;
      div   <= '0;
    end else begin
      if (wr_div) div <= sfr_wdata[DIV_W-1:0];
      if (wr_ctrl) en <= sfr_wdata[5];
      if (wr_ctrl && !busy) chsel <= sfr_wdata[0];
      if (done) eoc <= 1'b1;
      else if (wr_ctrl && !sfr_wdata[4]) eoc <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        pidle <= sfr_wdata[6];
      end else if (done || abort) begin
        busy  <= 1'b0;
        pidle <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || done || abort) begin
      dcnt     <= '0;
      ccnt     <= '0;
      conv_clk <= 1'b0;
    end else if (tick) begin
      dcnt     <= '0;
      conv_clk <= !conv_clk;
      if (!conv_clk) ccnt <= ccnt + CW'(1);
    end else begin
      dcnt <= dcnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    conv_result <= '0;
    else if (done) conv_result <= sample_in;
  end

  always_comb begin
    sfr_rdata = 8'h00;
    if (sfr_addr == ADDR_W'(CTRL_ADDR))
      sfr_rdata = {1'b0, pidle, en, eoc, busy, 2'b00, chsel};
    else if (sfr_addr == ADDR_W'(DIV_ADDR))
      sfr_rdata = {{(8-DIV_W){1'b0}}, div};
  end

  assign adc_chan    = !chsel;
  assign cpu_suspend = pidle;
  assign adc_irq     = eoc && irq_en;

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> en); // R3
  AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) conv_clk |-> busy); // R4
  AST_RESULT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(conv_result)); // R5
  AST_EOC_STICKY:    assert property (@(posedge clk) disable iff (!rst_n)
                       eoc && !(wr_ctrl && !sfr_wdata[4]) |=> eoc); // R6
  AST_SUSPEND_CONV:  assert property (@(posedge clk) disable iff (!rst_n) pidle |-> busy); // R8
  AST_STANDBY_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !en |-> !busy && !conv_clk); // R9
endmodule

// File: tb/tb_adc_ctl.sv
`timescale 1ns/1ps
module tb_adc_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'hF3;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       irq_en = 1'b0;
  logic [9:0] sample_in = '0;
  logic [9:0] conv_result;
  logic       conv_clk, adc_chan, cpu_suspend, adc_irq;

  int checks = 0;
  int errors = 0;

  adc_ctl dut (.clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
               .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_en(irq_en),
               .sample_in(sample_in), .conv_result(conv_result), .conv_clk(conv_clk),
               .adc_chan(adc_chan), .cpu_suspend(cpu_suspend), .adc_irq(adc_irq));

  always #4 clk = !clk;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog act timeout exp done");
    finish_run();
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = 8'hF3;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; #1; d = sfr_rdata; sfr_addr = 8'hF3;
  endtask

  function automatic logic [9:0] pat(input int k, input int n);
    return 10'((k * 37 + n * 101 + 5) & 10'h3FF);
  endfunction

  // poll from the current negedge; k counts negedges since the start write
  task automatic run_conv(input int k0, input int n, input bit susp,
                          output int busy_len, output int rises, output int first,
                          output logic [9:0] last, output int susp_bad);
    logic [7:0] r;
    bit prev = 1'b0;
    busy_len = 0; rises = 0; first = 0; susp_bad = 0; last = conv_result;
    for (int k = k0; k < 5000; k++) begin
      rd(8'hF3, r);
      if (!r[3]) break;
      busy_len = k;
      if (conv_clk && !prev) begin rises++; if (first == 0) first = k; end
      prev = conv_clk;
      if (cpu_suspend != susp) susp_bad++;
      sample_in = pat(k, n);
      last = sample_in;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] r;
    logic [9:0] last, held;
    int blen, rises, first, sbad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'hF3, r); check("R1 ctrl", r, 0);
    rd(8'hF2, r); check("R1 div", r, 0);
    check("R1 outs", {conv_clk, cpu_suspend, adc_irq}, 0);
    check("R1 chan", adc_chan, 1);
    check("R1 result", conv_result, 0);

    wr(8'hF2, 8'hFF); rd(8'hF2, r); check("R2 div reserved", r, 8'h1F);
    wr(8'hF3, 8'h87); rd(8'hF3, r); check("R2 ctrl reserved", r, 8'h01);
    check("R12 chan0", adc_chan, 0);
    rd(8'h55, r); check("R2 other addr", r, 0);
    rd(8'hF1, r); check("R2 neighbour addr", r, 0);
    wr(8'hF3, 8'h00); check("R12 chan1", adc_chan, 1);

    wr(8'hF3, 8'h48);
    sbad = 0;
    for (int i = 0; i < 60; i++) begin
      rd(8'hF3, r);
      if (r != 8'h00 || conv_clk || cpu_suspend) sbad++;
      @(negedge clk);
    end
    check("R9 standby start ignored", sbad, 0);
    check("R8 pidle without start", cpu_suspend, 0);

    for (int n = 0; n < 32; n++) begin
      bit s = n[0];
      irq_en = n[0];
      wr(8'hF2, 8'(n));
      wr(8'hF3, s ? 8'h68 : 8'h28);
      run_conv(1, n, s, blen, rises, first, last, sbad);
      check($sformatf("R3 busy len n=%0d", n), blen, 22 * (n + 1));
      check($sformatf("R4 rises n=%0d", n), rises, 11);
      check($sformatf("R4 first rise n=%0d", n), first, n + 2);
      check($sformatf("R8 suspend n=%0d", n), sbad, 0);
      check($sformatf("R5 result n=%0d", n), conv_result, last);
      rd(8'hF3, r); check($sformatf("R6 eoc set n=%0d", n), r, 8'h30);
      check($sformatf("R7 irq n=%0d", n), adc_irq, n[0]);
      check("R4 idle clk", conv_clk, 0);
      if (n == 5) begin
        repeat (20) @(negedge clk);
        rd(8'hF3, r); check("R6 eoc sticky", r, 8'h30);
      end
      wr(8'hF3, 8'h20);
      rd(8'hF3, r); check("R6 eoc cleared", r, 8'h20);
      check("R7 irq cleared", adc_irq, 0);
    end

    wr(8'hF3, 8'h30); rd(8'hF3, r); check("R6 write one no set", r, 8'h20);

    wr(8'hF2, 8'd3);
    wr(8'hF3, 8'h28);
    repeat (10) @(negedge clk);
    wr(8'hF3, 8'h79);
    run_conv(12, 3, 1'b0, blen, rises, first, last, sbad);
    check("R10 length unchanged", blen, 88);
    check("R10 suspend ignored", sbad, 0);
    check("R10 chan ignored", adc_chan, 1);
    check("R10 result", conv_result, last);
    rd(8'hF3, r); check("R10 status", r, 8'h30);
    wr(8'hF3, 8'h20);

    held = conv_result;
    wr(8'hF2, 8'd2);
    wr(8'hF3, 8'h68);
    sample_in = ~held;
    repeat (20) @(negedge clk);
    wr(8'hF3, 8'h40);
    sbad = 0;
    for (int i = 0; i < 100; i++) begin
      rd(8'hF3, r);
      if (r != 8'h00 || conv_clk || cpu_suspend || adc_irq) sbad++;
      @(negedge clk);
    end
    check("R11 abort idle", sbad, 0);
    check("R11 result kept", conv_result, held);

    finish_run();
  end
endmodule